// File: doc/BRIEF.md
# SPI Double-Buffered Data Register

This block is the data-holding stage between a CPU bus and an SPI shift engine. On the transmit side it keeps one holding word that the CPU loads byte by byte and that the shift engine takes when a transfer starts. On the receive side it keeps a visible receive word and a receive-full flag. It can also keep a second received word parked behind the visible one.

The CPU reaches the block through a small byte-wide register window. One status byte carries the receive-full and transmit-empty flags. Two data bytes serve two roles: writes load the transmit holding word, and reads return the received word. The shift engine signals the block with a one-cycle start pulse and a one-cycle completion pulse. The completion pulse carries the word that was just shifted in.

A word that completes while the visible word is still unread is parked. The CPU services the flag by reading the status byte and then a data byte. If it does this before the next transfer starts, the parked word is promoted into the visible register and the flag stays set. If a transfer starts first, the parked word is discarded.

Top module: `spi_xfer_buffer`

## Requirements
- R1: After reset, rx_full is 0, tx_empty is 1, eng_tx_word is 0, and both data bytes read 0.
- R2: Reads at offset 3 return the status byte, with bit 7 = rx_full, bit 5 = tx_empty and all other bits 0. Offset 4 reads the high byte of the received word and offset 5 reads the low byte. Any other offset reads 0. bus_rdata is valid in the cycle the read is presented.
- R3: A write to offset 4 (or 5) replaces the high (or low) byte of eng_tx_word and clears tx_empty from the next cycle on.
- R4: An eng_start pulse sets tx_empty from the next cycle on. If a data write lands in the same cycle, tx_empty stays 0 and eng_tx_word still shows the old word in that cycle.
- R5: An eng_done pulse while rx_full is 0 makes eng_rx_word the visible received word and sets rx_full, both from the next cycle on.
- R6: An eng_done pulse while rx_full is 1 and not being serviced leaves the visible word unchanged. The new word is parked as pending.
- R7: Servicing means a status read while rx_full is 1, followed later by a read of either data byte. With no pending word, the service read clears rx_full from the next cycle on.
- R8: A service read while a word is pending moves the pending word into the visible register and keeps rx_full at 1.
- R9: An eng_start pulse while a word is pending and no service read is in that cycle discards the pending word. The visible word and rx_full are kept.
- R10: When a service read and eng_done fall in the same cycle, the service is applied first. With no pending word, the new word becomes visible and rx_full stays 1. With a pending word, that word is promoted and the new word is parked.
- R11: When a service read and eng_start fall in the same cycle, the service is applied first, so a pending word is promoted rather than discarded.
- R12: A data read that is not preceded by a status read taken while rx_full was set does not service the flag. rx_full and the visible word are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational for the current access |
| eng_start | input | 1 | Shift engine starts a transfer and takes eng_tx_word |
| eng_done | input | 1 | Shift engine finished a transfer |
| eng_rx_word | input | 16 | Received word, valid with eng_done |
| eng_tx_word | output | 16 | Transmit holding word |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit-empty flag |

## Verification
Three receive-side events can collide: the service read can land in the same cycle as a transfer completion or as a transfer start. The bench builds each starting state, with and without a parked word, and arms the flag with a status read when the case needs it. It then fires every combination of data read, eng_done and eng_start in one cycle. The outcome is judged by reading the visible word without servicing, then servicing once more to expose whether a parked word survived. Each result is compared with a model that applies service first, then start, then completion.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  localparam int STAT_RXF_BIT = 7;
  localparam int STAT_TXE_BIT = 5;

  // outcome of one cycle of receive-side bookkeeping
  typedef struct packed {
    logic full;
    logic pend;
    logic promote;
    logic clear;
    logic drop;
    logic park;
    logic load;
  } rx_step_t;

  // order inside a cycle: service, then transfer start, then completion
  function automatic rx_step_t rx_next(input logic full, input logic pend,
                                       input logic svc, input logic start,
                                       input logic done);
    rx_step_t s;
    logic full_a;
    logic pend_a;
    s      = '0;
    full_a = full;
    pend_a = pend;
    if (svc && full) begin
      if (pend) begin
        s.promote = 1'b1;
        pend_a    = 1'b0;
      end else begin
        s.clear = 1'b1;
        full_a  = 1'b0;
      end
    end
    if (start && pend_a) begin
      s.drop = 1'b1;
      pend_a = 1'b0;
    end
    if (done) begin
      if (full_a) begin
        s.park = 1'b1;
        pend_a = 1'b1;
      end else begin
        s.load = 1'b1;
        full_a = 1'b1;
      end
    end
    s.full = full_a;
    s.pend = pend_a;
    return s;
  endfunction

  function automatic logic [7:0] status_byte(input logic full, input logic txe);
    logic [7:0] b;
    b               = '0;
    b[STAT_RXF_BIT] = full;
    b[STAT_TXE_BIT] = txe;
    return b;
  endfunction

endpackage

// File: rtl/spi_dbuf_decode.sv
module spi_dbuf_decode #(
  parameter int ADDR_W   = 3,
  parameter int NBYTES   = 2,
  parameter int STAT_OFS = 3,
  parameter int DATA_OFS = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              stat_rd,
  output logic [NBYTES-1:0] byte_rd,
  output logic [NBYTES-1:0] byte_wr
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  assign stat_rd = bus_sel && !bus_wr && (bus_addr == STAT_A);

  // offset DATA_OFS+i selects byte lane NBYTES-1-i (most significant first)
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(DATA_OFS + i);
    assign byte_rd[i] = bus_sel && !bus_wr && (bus_addr == LANE_A);
    assign byte_wr[i] = bus_sel &&  bus_wr && (bus_addr == LANE_A);
  end

endmodule

// File: rtl/spi_dbuf_tx.sv
module spi_dbuf_tx #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W/BYTE_W-1:0] byte_wr,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     start,
  output logic [DATA_W-1:0]        tx_word,
  output logic                     tx_empty
);

  localparam int NBYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] hold_q;
  logic              empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (byte_wr[i]) hold_q[(NBYTES-1-i)*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  // a write in the same cycle as a start queues a fresh word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          empty_q <= 1'b1;
    else if (|byte_wr)   empty_q <= 1'b0;
    else if (start)      empty_q <= 1'b1;
  end

  assign tx_word  = hold_q;
  assign tx_empty = empty_q;

endmodule

// File: rtl/spi_dbuf_rx.sv
module spi_dbuf_rx
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              start,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] pend_word,
  output logic              rx_full,
  output logic              pending,
  output logic              svc_evt,
  output logic              promote_evt,
  output logic              drop_evt,
  output logic              park_evt,
  output logic              load_evt
);

  logic              full_q;
  logic              pend_q;
  logic              armed_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pword_q;
  rx_step_t          step;

  assign svc_evt = armed_q && data_rd;
  assign step    = rx_next(full_q, pend_q, svc_evt, start, done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      data_q  <= '0;
      pword_q <= '0;
    end else begin
      full_q <= step.full;
      pend_q <= step.pend;
      if (svc_evt)                armed_q <= 1'b0;
      else if (stat_rd && full_q) armed_q <= 1'b1;
      if (step.promote)   data_q <= pword_q;
      else if (step.load) data_q <= rx_in;
      if (step.park)      pword_q <= rx_in;
    end
  end

  assign rx_data     = data_q;
  assign pend_word   = pword_q;
  assign rx_full     = full_q;
  assign pending     = pend_q;
  assign promote_evt = step.promote;
  assign drop_evt    = step.drop;
  assign park_evt    = step.park;
  assign load_evt    = step.load;

endmodule

// File: rtl/spi_xfer_buffer.sv
module spi_xfer_buffer
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int STAT_OFS = 3,
  parameter int DATA_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              eng_start,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx_word,
  output logic [DATA_W-1:0] eng_tx_word,
  output logic              rx_full,
  output logic              tx_empty
);

  localparam int NBYTES = DATA_W / BYTE_W;

  logic              stat_rd;
  logic [NBYTES-1:0] byte_rd;
  logic [NBYTES-1:0] byte_wr;
  logic              data_rd;
  logic              data_wr;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] pend_word;
  logic              pending;
  logic              svc_evt;
  logic              promote_evt;
  logic              drop_evt;
  logic              park_evt;
  logic              load_evt;

  spi_dbuf_decode #(
    .ADDR_W(ADDR_W), .NBYTES(NBYTES), .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .stat_rd (stat_rd),
    .byte_rd (byte_rd),
    .byte_wr (byte_wr)
  );

  assign data_rd = |byte_rd;
  assign data_wr = |byte_wr;

  spi_dbuf_tx #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_wr (byte_wr),
    .wdata   (bus_wdata),
    .start   (eng_start),
    .tx_word (eng_tx_word),
    .tx_empty(tx_empty)
  );

  spi_dbuf_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .start      (eng_start),
    .done       (eng_done),
    .rx_in      (eng_rx_word),
    .rx_data    (rx_data),
    .pend_word  (pend_word),
    .rx_full    (rx_full),
    .pending    (pending),
    .svc_evt    (svc_evt),
    .promote_evt(promote_evt),
    .drop_evt   (drop_evt),
    .park_evt   (park_evt),
    .load_evt   (load_evt)
  );

  always_comb begin
    bus_rdata = '0;
    if (stat_rd) bus_rdata = BYTE_W'(status_byte(rx_full, tx_empty));
    for (int i = 0; i < NBYTES; i++) begin
      if (byte_rd[i]) bus_rdata = rx_data[(NBYTES-1-i)*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_start,
  input logic              eng_done,
  input logic [DATA_W-1:0] eng_rx_word,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              data_wr,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] pend_word,
  input logic              pending,
  input logic              svc_evt,
  input logic              promote_evt,
  input logic              drop_evt,
  input logic              park_evt,
  input logic              load_evt
);

  AST_TX_WRITE_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_empty); // R3

  AST_TX_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !data_wr && !tx_empty |=> tx_empty); // R4

  AST_LOAD_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !rx_full |=> rx_full && rx_data == $past(eng_rx_word)); // R5

  AST_FULL_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && rx_full && !svc_evt |=> $stable(rx_data) && pending); // R6

  AST_PEND_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> rx_full); // R6

  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt && !pending && !eng_done |=> !rx_full); // R7

  AST_PROMOTE_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt && pending |=> rx_full && rx_data == $past(pend_word)); // R8

  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && pending && !svc_evt && !eng_done |=> !pending && rx_full); // R9

  AST_SERVICE_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt && pending |-> !drop_evt && promote_evt); // R11

  AST_ONE_RX_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({park_evt, load_evt})); // R10

endmodule

bind spi_xfer_buffer spi_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_start  (eng_start),
  .eng_done   (eng_done),
  .eng_rx_word(eng_rx_word),
  .rx_full    (rx_full),
  .tx_empty   (tx_empty),
  .data_wr    (data_wr),
  .rx_data    (rx_data),
  .pend_word  (pend_word),
  .pending    (pending),
  .svc_evt    (svc_evt),
  .promote_evt(promote_evt),
  .drop_evt   (drop_evt),
  .park_evt   (park_evt),
  .load_evt   (load_evt)
);

// File: tb/spi_xfer_buffer_tb.sv
module spi_xfer_buffer_tb;

  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_HI   = 3'd4;
  localparam logic [2:0] A_LO   = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        eng_start = 1'b0;
  logic        eng_done = 1'b0;
  logic [15:0] eng_rx_word = '0;
  logic [15:0] eng_tx_word;
  logic        rx_full;
  logic        tx_empty;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [7:0]  rd_cap;
  logic [15:0] tx_cap;

  always #4 clk = ~clk;

  spi_xfer_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_done(eng_done), .eng_rx_word(eng_rx_word),
    .eng_tx_word(eng_tx_word), .rx_full(rx_full), .tx_empty(tx_empty)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle, called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                     input logic [7:0] d, input logic st, input logic dn,
                     input logic [15:0] rw);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    eng_start = st; eng_done = dn; eng_rx_word = rw;
    #1;
    rd_cap = bus_rdata;
    tx_cap = eng_tx_word;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; eng_start = 1'b0; eng_done = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] wa, wb, wc, e_data, e_pw;
    logic        e_full, e_pend;
    string       tag;

    do_reset();
    // R1 reset state
    chk("R1 rx_full", {15'b0, rx_full}, 16'h0);
    chk("R1 tx_empty", {15'b0, tx_empty}, 16'h1);
    chk("R1 tx_word", eng_tx_word, 16'h0);
    rd(A_HI); chk("R1 hi", {8'h0, rd_cap}, 16'h0);
    rd(A_LO); chk("R1 lo", {8'h0, rd_cap}, 16'h0);
    // R2 map
    rd(A_STAT); chk("R2 status empty", {8'h0, rd_cap}, 16'h0020);
    for (int a = 0; a < 8; a++) begin
      if (a < 3 || a > 5) begin
        rd(3'(a)); chk("R2 unmapped", {8'h0, rd_cap}, 16'h0);
      end
    end
    // R3 transmit loading
    wr(A_HI, 8'hAB);
    chk("R3 tx_empty", {15'b0, tx_empty}, 16'h0);
    chk("R3 word hi", eng_tx_word, 16'hAB00);
    wr(A_LO, 8'hCD);
    chk("R3 word lo", eng_tx_word, 16'hABCD);
    rd(A_STAT); chk("R2 status txe clear", {8'h0, rd_cap}, 16'h0000);
    // R4 start and collision with write
    cyc(1'b0, 1'b0, 3'd0, 8'h0, 1'b1, 1'b0, 16'h0);
    chk("R4 start", {15'b0, tx_empty}, 16'h1);
    cyc(1'b1, 1'b1, A_HI, 8'h12, 1'b1, 1'b0, 16'h0);
    chk("R4 old word at start", tx_cap, 16'hABCD);
    chk("R4 write wins", {15'b0, tx_empty}, 16'h0);
    chk("R4 new word", eng_tx_word, 16'h12CD);
    // R5 / R12
    cyc(1'b0, 1'b0, 3'd0, 8'h0, 1'b0, 1'b1, 16'h5A3C);
    chk("R5 full", {15'b0, rx_full}, 16'h1);
    rd(A_HI); chk("R12 hi", {8'h0, rd_cap}, 16'h005A);
    rd(A_LO); chk("R12 lo", {8'h0, rd_cap}, 16'h003C);
    chk("R12 still full", {15'b0, rx_full}, 16'h1);
    rd(A_STAT); chk("R2 status full", {8'h0, rd_cap}, 16'h0080);
    rd(A_LO);
    chk("R7 cleared", {15'b0, rx_full}, 16'h0);

    // sweep: prior pending x {service, done, start} in one cycle
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic sv, dn, st;
        sv = c[0]; dn = c[1]; st = c[2];
        wa = 16'h1100 | 16'(p * 8 + c);
        wb = 16'h2200 | 16'(p * 8 + c);
        wc = 16'h3300 | 16'(p * 8 + c);
        if (sv && dn)        tag = "R10";
        else if (sv && st)   tag = "R11";
        else if (st && p==1) tag = "R9";
        else if (dn)         tag = "R6";
        else if (sv && p==1) tag = "R8";
        else if (sv)         tag = "R7";
        else                 tag = "R12";
        do_reset();
        cyc(1'b0, 1'b0, 3'd0, 8'h0, 1'b0, 1'b1, wa);
        if (p == 1) begin
          cyc(1'b0, 1'b0, 3'd0, 8'h0, 1'b1, 1'b0, 16'h0);
          cyc(1'b0, 1'b0, 3'd0, 8'h0, 1'b0, 1'b1, wb);
        end
        if (sv) rd(A_STAT);
        cyc(sv, 1'b0, A_HI, 8'h0, st, dn, wc);
        if (sv) chk({tag, " read in event cycle"}, {8'h0, rd_cap}, {8'h0, wa[15:8]});
        // expected: service, then start, then completion
        e_full = 1'b1; e_data = wa; e_pend = p[0]; e_pw = wb;
        if (sv) begin
          if (e_pend) begin e_data = e_pw; e_pend = 1'b0; end
          else e_full = 1'b0;
        end
        if (st && e_pend) e_pend = 1'b0;
        if (dn) begin
          if (e_full) begin e_pend = 1'b1; e_pw = wc; end
          else begin e_full = 1'b1; e_data = wc; end
        end
        chk({tag, " rx_full"}, {15'b0, rx_full}, {15'b0, e_full});
        rd(A_HI); chk({tag, " word hi"}, {8'h0, rd_cap}, {8'h0, e_data[15:8]});
        rd(A_LO); chk({tag, " word lo"}, {8'h0, rd_cap}, {8'h0, e_data[7:0]});
        if (e_full) begin
          rd(A_STAT);
          rd(A_HI);
          chk({tag, " after service full"}, {15'b0, rx_full}, {15'b0, e_pend});
          if (e_pend) begin
            rd(A_HI); chk({tag, " parked hi"}, {8'h0, rd_cap}, {8'h0, e_pw[15:8]});
            rd(A_LO); chk({tag, " parked lo"}, {8'h0, rd_cap}, {8'h0, e_pw[7:0]});
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule